// File: doc/BRIEF.md
# Inband Loopback Code Generator

This block replaces the outgoing bit stream of chosen line channels with a repeating loopback control code, which asks the far end to enter or leave a remote loop. Two 8-bit pattern words and two 2-bit length fields are shared with the loopback code detector. Each pattern word holds its code already repeated to fill the byte, and the length field says how many of its leading bits form one period. A single select input chooses which of the two codes goes out. An enable bitmap with one bit per channel says which channels carry the code. Every other channel passes its own transmit data through.

The transmit path is a bit stream with one strobe per channel. Each strobe is one bit slot. The block never applies back-pressure: each strobe is accepted in the cycle it is seen, and a valid strobe comes out one clock later. A channel that is not strobed holds its output. Code generation and code detection must not run at the same time, so while the detection enable input is high, all enable requests are ignored and every channel carries normal data. Whenever a channel's effective enable goes from off to on, its code starts again from the first bit.

Top module: `lbk_code_gen`

## Requirements
- R1: During reset and in the first cycle after it, `tx_out_o` and `tx_vld_o` are all zeros.
- R2: For each channel, `tx_vld_o[c]` is the value `tick_i[c]` had on the previous clock edge. No strobe is ever refused or stalled.
- R3: On a strobed channel whose enable bit is 0, `tx_out_o[c]` takes the value `tx_in_i[c]` one clock after the strobe.
- R4: The length field code maps 2'b00, 2'b01, 2'b10 and 2'b11 to 5, 6, 7 and 8 bits. Over successive strobes, an enabled channel sends pattern bits 7, 6, ... down to bit 8-N, then starts again at bit 7.
- R5: When `code_sel_i` is 0, the activate pattern and activate length are used. When it is 1, the deactivate pattern and deactivate length are used.
- R6: The first strobe after a channel's effective enable goes from 0 to 1 sends bit 7 of the selected pattern.
- R7: After a channel's enable bit is cleared, the next strobe sends normal data on that channel.
- R8: While `det_en_i` is 1, every strobed channel outputs `tx_in_i`, whatever `gen_en_i` holds. When `det_en_i` falls with the enable bit still set, the next strobe sends bit 7.
- R9: Enable bit c acts only on channel c. For example, the value 8'h02 puts the code on channel 1 alone.
- R10: `tx_out_o[c]` does not change in a cycle that follows no strobe on channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_en_i | input | 1 | Loopback code detection is enabled; blocks generation |
| code_sel_i | input | 1 | 0 sends the activate code, 1 sends the deactivate code |
| act_pat_i | input | 8 | Activate pattern, repeated, MSB first |
| deact_pat_i | input | 8 | Deactivate pattern, repeated, MSB first |
| act_len_i | input | 2 | Activate length code (5 + value bits) |
| deact_len_i | input | 2 | Deactivate length code (5 + value bits) |
| gen_en_i | input | NCH | Per-channel generation enable bitmap |
| tick_i | input | NCH | Per-channel bit strobe (input valid) |
| tx_in_i | input | NCH | Per-channel normal transmit bit |
| tx_out_o | output | NCH | Per-channel transmit bit out |
| tx_vld_o | output | NCH | Per-channel output valid, one clock after the strobe |

## Verification
The bench steps every length code with both code selections and checks the bit stream on one channel against hand-derived streams.

Each corner case is aimed at a specific error:
- **Period wrap:** a design that wraps at the wrong count drops or repeats a bit at the period boundary.
- **Length source:** a design that takes its length from the unselected field sends a period of the wrong size.
- **Mid-stream stop and restart:** a design that keeps its phase across a disable resumes in mid-code instead of at bit 7.
- **Detection enable:** if detection is raised while channels are enabled, a design that ignores it puts code bits on the line.
- **Neighbour channels and idle cycles:** these expose a wrong channel mapping, and an output that changes without a strobe.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  localparam int PAT_W = 8;
  localparam int LEN_W = 2;
  localparam int MIN_BITS = PAT_W - 3;
  localparam int PH_W = $clog2(PAT_W);
  localparam int NB_W = PH_W + 1;

  typedef struct packed {
    logic [PAT_W-1:0] pat;
    logic [NB_W-1:0]  nbits;
  } code_t;

  function automatic logic [NB_W-1:0] len_to_bits(input logic [LEN_W-1:0] len);
    return NB_W'(MIN_BITS) + NB_W'(len);
  endfunction
endpackage

// File: rtl/lbk_code_sel.sv
module lbk_code_sel
  import lbk_pkg::*;
(
  input  logic             sel_i,
  input  logic [PAT_W-1:0] act_pat_i,
  input  logic [PAT_W-1:0] deact_pat_i,
  input  logic [LEN_W-1:0] act_len_i,
  input  logic [LEN_W-1:0] deact_len_i,
  output code_t            code_o
);
  always_comb begin
    if (sel_i) begin
      code_o.pat   = deact_pat_i;
      code_o.nbits = len_to_bits(deact_len_i);
    end else begin
      code_o.pat   = act_pat_i;
      code_o.nbits = len_to_bits(act_len_i);
    end
  end
endmodule

// File: rtl/lbk_excl_gate.sv
module lbk_excl_gate #(
  parameter int NCH = 8
) (
  input  logic           det_en_i,
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] eff_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign eff_o[c] = req_i[c] & ~det_en_i;
  end
endmodule

// File: rtl/lbk_chan_gen.sv
module lbk_chan_gen
  import lbk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t code_i,
  input  logic  eff_en_i,
  input  logic  tick_i,
  input  logic  tx_in_i,
  output logic  tx_out_o,
  output logic  tx_vld_o
);
  localparam logic [PH_W-1:0] TOP_IDX = PH_W'(PAT_W - 1);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] bit_idx;
  logic            at_last;

  assign bit_idx = TOP_IDX - phase_q;
  // wrap at the end of the period; also catches a length cut mid-stream
  assign at_last = ({1'b0, phase_q} >= (code_i.nbits - NB_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= '0;
      tx_out_o <= 1'b0;
      tx_vld_o <= 1'b0;
    end else begin
      tx_vld_o <= tick_i;
      if (!eff_en_i) begin
        phase_q <= '0;
      end else if (tick_i) begin
        phase_q <= at_last ? '0 : phase_q + PH_W'(1);
      end
      if (tick_i) begin
        tx_out_o <= eff_en_i ? code_i.pat[bit_idx] : tx_in_i;
      end
    end
  end
endmodule

// File: rtl/lbk_code_gen.sv
module lbk_code_gen
  import lbk_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_en_i,
  input  logic             code_sel_i,
  input  logic [PAT_W-1:0] act_pat_i,
  input  logic [PAT_W-1:0] deact_pat_i,
  input  logic [LEN_W-1:0] act_len_i,
  input  logic [LEN_W-1:0] deact_len_i,
  input  logic [NCH-1:0]   gen_en_i,
  input  logic [NCH-1:0]   tick_i,
  input  logic [NCH-1:0]   tx_in_i,
  output logic [NCH-1:0]   tx_out_o,
  output logic [NCH-1:0]   tx_vld_o
);
  code_t          cur_code;
  logic [NCH-1:0] eff_en;

  lbk_code_sel u_sel (
    .sel_i       (code_sel_i),
    .act_pat_i   (act_pat_i),
    .deact_pat_i (deact_pat_i),
    .act_len_i   (act_len_i),
    .deact_len_i (deact_len_i),
    .code_o      (cur_code)
  );

  lbk_excl_gate #(.NCH(NCH)) u_gate (
    .det_en_i (det_en_i),
    .req_i    (gen_en_i),
    .eff_o    (eff_en)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    lbk_chan_gen u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .code_i   (cur_code),
      .eff_en_i (eff_en[c]),
      .tick_i   (tick_i[c]),
      .tx_in_i  (tx_in_i[c]),
      .tx_out_o (tx_out_o[c]),
      .tx_vld_o (tx_vld_o[c])
    );
  end
endmodule

// File: rtl/lbk_code_gen_chk.sv
module lbk_code_gen_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           det_en_i,
  input logic           code_sel_i,
  input logic [7:0]     act_pat_i,
  input logic [7:0]     deact_pat_i,
  input logic [NCH-1:0] gen_en_i,
  input logic [NCH-1:0] tick_i,
  input logic [NCH-1:0] tx_in_i,
  input logic [NCH-1:0] tx_out_o,
  input logic [NCH-1:0] tx_vld_o
);
  logic [NCH-1:0] want_code;
  assign want_code = gen_en_i & ~{NCH{det_en_i}};

  p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tx_vld_o == $past(tick_i));

  p_pass_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((tx_out_o ^ $past(tx_in_i)) & $past(tick_i & ~want_code)) == '0);

  p_det_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    det_en_i |=> ((tx_out_o ^ $past(tx_in_i)) & $past(tick_i)) == '0);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((tx_out_o ^ $past(tx_out_o)) & ~$past(tick_i)) == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_first
    p_first_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i[c] && want_code[c] && !$past(want_code[c]))
        |=> tx_out_o[c] == $past(code_sel_i ? deact_pat_i[7] : act_pat_i[7]));
  end
endmodule

bind lbk_code_gen lbk_code_gen_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .det_en_i    (det_en_i),
  .code_sel_i  (code_sel_i),
  .act_pat_i   (act_pat_i),
  .deact_pat_i (deact_pat_i),
  .gen_en_i    (gen_en_i),
  .tick_i      (tick_i),
  .tx_in_i     (tx_in_i),
  .tx_out_o    (tx_out_o),
  .tx_vld_o    (tx_vld_o)
);

// File: tb/lbk_code_gen_test.sv
module lbk_code_gen_test;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           det_en_i = 1'b0;
  logic           code_sel_i = 1'b0;
  logic [7:0]     act_pat_i = '0;
  logic [7:0]     deact_pat_i = '0;
  logic [1:0]     act_len_i = '0;
  logic [1:0]     deact_len_i = '0;
  logic [NCH-1:0] gen_en_i = '0;
  logic [NCH-1:0] tick_i = '0;
  logic [NCH-1:0] tx_in_i = '0;
  logic [NCH-1:0] tx_out_o;
  logic [NCH-1:0] tx_vld_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lbk_code_gen #(.NCH(NCH)) uut (.*);

  typedef struct packed {
    logic [7:0]  act;
    logic [7:0]  deact;
    logic [1:0]  alen;
    logic [1:0]  dlen;
    logic        sel;
    logic [2:0]  chan;
    logic [11:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'hC6, 8'hE7, 2'b00, 2'b00, 1'b0, 3'd1, 12'b1100_0110_0011},
    '{8'hC6, 8'hE7, 2'b00, 2'b00, 1'b1, 3'd0, 12'b1110_0111_0011},
    '{8'hA5, 8'h00, 2'b11, 2'b00, 1'b0, 3'd7, 12'b1010_0101_1010},
    '{8'h96, 8'hFF, 2'b01, 2'b11, 1'b0, 3'd4, 12'b1001_0110_0101},
    '{8'hFF, 8'h3C, 2'b00, 2'b10, 1'b1, 3'd2, 12'b0011_1100_0111},
    '{8'hF0, 8'h0F, 2'b10, 2'b00, 1'b0, 3'd5, 12'b1111_0001_1110}
  };

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // strobe the masked channels for one cycle; returns at the negedge after the update
  task automatic strobe(input logic [NCH-1:0] m);
    @(negedge clk);
    tick_i = m;
    @(negedge clk);
    tick_i = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NCH-1:0] held;
    repeat (3) @(negedge clk);
    chk("R1 reset out", tx_out_o, '0);
    chk("R1 reset vld", tx_vld_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset out", tx_out_o, '0);
    chk("R1 after reset vld", tx_vld_o, '0);

    // vector table: R4 length/order, R5 select, R9 channel isolation, R10 hold, R7 stop
    foreach (VECS[i]) begin
      act_pat_i = VECS[i].act;
      deact_pat_i = VECS[i].deact;
      act_len_i = VECS[i].alen;
      deact_len_i = VECS[i].dlen;
      code_sel_i = VECS[i].sel;
      tx_in_i = 8'h55;
      gen_en_i = NCH'(1) << VECS[i].chan;
      for (int k = 0; k < 12; k++) begin
        strobe('1);
        chk("R4 R5 code bit", NCH'(tx_out_o[VECS[i].chan]), NCH'(VECS[i].exp[11-k]));
        chk("R9 other channels", tx_out_o & ~gen_en_i, tx_in_i & ~gen_en_i);
      end
      held = tx_out_o;
      @(negedge clk);
      chk("R10 hold without strobe", tx_out_o, held);
      chk("R2 vld idle", tx_vld_o, '0);
      gen_en_i = '0;
      strobe('1);
      chk("R7 stop returns normal data", tx_out_o, tx_in_i);
    end

    // R3 pass-through with several patterns
    tx_in_i = 8'hA5;
    strobe('1);
    chk("R3 pass A5", tx_out_o, 8'hA5);
    chk("R2 vld after strobe", tx_vld_o, '1);
    tx_in_i = 8'h00;
    strobe('1);
    chk("R3 pass 00", tx_out_o, 8'h00);

    // R2 partial strobe: only channel 0 moves
    tx_in_i = 8'hFF;
    strobe(8'h01);
    chk("R2 partial vld", tx_vld_o, 8'h01);
    chk("R10 unstrobed channels hold", tx_out_o, 8'h01);

    // R7/R6 mid-code stop and restart on channel 3, code 11000
    act_pat_i = 8'hC6; act_len_i = 2'b00; code_sel_i = 1'b0;
    tx_in_i = 8'h00;
    gen_en_i = 8'h08;
    strobe('1); chk("R6 first bit", NCH'(tx_out_o[3]), NCH'(1));
    strobe('1); chk("R4 second bit", NCH'(tx_out_o[3]), NCH'(1));
    strobe('1); chk("R4 third bit", NCH'(tx_out_o[3]), NCH'(0));
    gen_en_i = 8'h00;
    strobe('1); chk("R7 mid-code stop", tx_out_o, 8'h00);
    gen_en_i = 8'h08;
    strobe('1); chk("R6 restart bit7", NCH'(tx_out_o[3]), NCH'(1));
    strobe('1); chk("R6 restart bit6", NCH'(tx_out_o[3]), NCH'(1));
    strobe('1); chk("R6 restart bit5", NCH'(tx_out_o[3]), NCH'(0));

    // R8 detection blocks generation
    det_en_i = 1'b1;
    gen_en_i = '1;
    tx_in_i = 8'h0F;
    strobe('1); chk("R8 det blocks", tx_out_o, 8'h0F);
    strobe('1); chk("R8 det still blocks", tx_out_o, 8'h0F);
    det_en_i = 1'b0;
    strobe('1); chk("R8 release starts bit7", tx_out_o, 8'hFF);
    strobe('1); chk("R8 then bit6", tx_out_o, 8'hFF);
    strobe('1); chk("R8 then bit5", tx_out_o, 8'h00);
    det_en_i = 1'b1;
    strobe('1); chk("R8 det mid-stream", tx_out_o, 8'h0F);
    det_en_i = 1'b0;
    strobe('1); chk("R8 re-release bit7", tx_out_o, 8'hFF);

    // R5 select switched to deactivate code, restart through enable
    gen_en_i = '0;
    strobe('1);
    deact_pat_i = 8'hE7; deact_len_i = 2'b00; code_sel_i = 1'b1;
    gen_en_i = 8'h02;
    strobe('1); chk("R5 deact bit7", tx_out_o, 8'h02 | (tx_in_i & 8'hFD));
    strobe('1); chk("R5 deact bit6", tx_out_o, 8'h02 | (tx_in_i & 8'hFD));
    strobe('1); chk("R5 deact bit5", tx_out_o, 8'h02 | (tx_in_i & 8'hFD));
    strobe('1); chk("R5 deact bit4", tx_out_o, tx_in_i & 8'hFD);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule